// File: doc/BRIEF.md
# Serial Byte Receiver with Even-Parity Check

This block recovers bytes from an asynchronous serial line. Each frame has a low start bit, eight data bits sent least significant bit first, one parity bit and a high stop bit. The serial input first passes through a two-flop synchronizer. A falling level on the synchronized line arms a half-bit timer. If the line is still low at the middle of the start bit, the frame is accepted. Every later bit is then taken once per full bit period, so each sample lands close to the centre of its bit. The bit timer restarts on every start edge, so a small rate mismatch between sender and receiver cannot build up from one frame to the next.

When the stop bit is sampled, the block presents the assembled byte together with two flags. The first flag reports a parity mismatch, where even parity over the data and parity bits is expected. The second reports a stop bit read as low. A single-cycle valid strobe accompanies them. All outputs are registered, and they hold their values until the next frame completes. The bit period is set in clock cycles by a parameter, and the default suits roughly 57600 baud from a 100 MHz clock.

Top module: `uart_par_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `rx_valid` is 0 and `rx_byte`, `rx_parity_err` and `rx_frame_err` are all 0.
- R2: A low pulse on the line that is over before the middle of the start bit, which comes (CLKS_PER_BIT-1)/2 cycles after the synchronized edge, is treated as a false start. It produces no strobe, and a frame that follows it is received correctly.
- R3: The first data bit after the start bit lands in `rx_byte[0]`, and the eighth lands in `rx_byte[7]`.
- R4: `rx_parity_err` is 1 exactly when the number of ones across the eight data bits and the parity bit is odd.
- R5: `rx_frame_err` is 1 exactly when the stop bit is sampled as 0. A following frame with a high stop bit clears it.
- R6: `rx_valid` is high for exactly one cycle per accepted frame. The byte and both flags change only in that cycle and hold their values afterwards.
- R7: The bit timer restarts on each start edge. Frames sent back to back with a bit period 1/32 longer than nominal are all decoded correctly.
- R8: The strobe appears 10*CLKS_PER_BIT + (CLKS_PER_BIT-1)/2 + 4 clock cycles after the line first goes low. This count includes the two synchronizer stages and the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rx_byte | output | DATA_BITS (8) | Most recently received byte |
| rx_parity_err | output | 1 | Even-parity mismatch for that byte |
| rx_frame_err | output | 1 | Stop bit of that frame was low |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |

## Verification
The parity check and the stop-bit check both resolve in the same stop-sample cycle. Both also load their results in the cycle that raises the strobe. One scenario sends a byte with its parity bit inverted and its stop bit held low, and it expects a single strobe with both flags set and the byte still correct. Another sends a low stop bit, leaves the line low into what the receiver sees as a new start, and confirms that this tail is rejected as a false start rather than producing a second strobe.

// File: rtl/uart_par_rx_pkg.sv
package uart_par_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rx_phase_e;
endpackage

// File: rtl/uart_par_rx_sync.sv
module uart_par_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // idle level of the line is high, so reset to ones
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_par_rx_bitcnt.sv
module uart_par_rx_bitcnt #(
  parameter int CLKS_PER_BIT = 1736
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic at_mid,
  output logic at_end
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam logic [CNT_W-1:0] MID_V = CNT_W'((CLKS_PER_BIT - 1) / 2);
  localparam logic [CNT_W-1:0] END_V = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)    cnt <= '0;
    else if (cnt == END_V) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign at_mid = (cnt == MID_V);
  assign at_end = (cnt == END_V);
endmodule

// File: rtl/uart_par_rx_shreg.sv
module uart_par_rx_shreg #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [DATA_BITS-1:0] data,
  output logic                 ones_odd
);
  // new bits enter at the top; after DATA_BITS shifts the first one sits at bit 0
  always_ff @(posedge clk) begin
    if (rst)           data <= '0;
    else if (shift_en) data <= {bit_in, data[DATA_BITS-1:1]};
  end

  assign ones_odd = ^data;
endmodule

// File: rtl/uart_par_rx_ctrl.sv
module uart_par_rx_ctrl
  import uart_par_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_s,
  input  logic                 at_mid,
  input  logic                 at_end,
  input  logic [DATA_BITS-1:0] shift_data,
  input  logic                 data_odd,
  output logic                 cnt_restart,
  output logic                 shift_en,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_parity_err,
  output logic                 rx_frame_err,
  output logic                 rx_valid
);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rx_phase_e        state, nxt;
  logic [IDX_W-1:0] idx;
  logic             par_bit;
  logic             stop_hit;

  assign cnt_restart = (state == RX_IDLE) || (state == RX_START && at_mid);
  assign shift_en    = (state == RX_DATA) && at_end;
  assign stop_hit    = (state == RX_STOP) && at_end;

  always_comb begin
    nxt = state;
    unique case (state)
      RX_IDLE:   if (!rx_s) nxt = RX_START;
      RX_START:  if (at_mid) nxt = rx_s ? RX_IDLE : RX_DATA;
      RX_DATA:   if (at_end && idx == LAST_IDX) nxt = RX_PARITY;
      RX_PARITY: if (at_end) nxt = RX_STOP;
      RX_STOP:   if (at_end) nxt = RX_IDLE;
      default:   nxt = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      idx     <= '0;
      par_bit <= 1'b0;
    end else begin
      state <= nxt;
      if (state == RX_START)                 idx <= '0;
      else if (shift_en)                     idx <= idx + 1'b1;
      if (state == RX_PARITY && at_end)      par_bit <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte       <= '0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
      rx_valid      <= 1'b0;
    end else begin
      rx_valid <= stop_hit;
      if (stop_hit) begin
        rx_byte       <= shift_data;
        rx_parity_err <= data_odd ^ par_bit;
        rx_frame_err  <= ~rx_s;
      end
    end
  end
endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx #(
  parameter int CLKS_PER_BIT = 1736,
  parameter int DATA_BITS    = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_serial,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_parity_err,
  output logic                 rx_frame_err,
  output logic                 rx_valid
);
  logic                 rx_s;
  logic                 at_mid, at_end;
  logic                 cnt_restart, shift_en;
  logic [DATA_BITS-1:0] shift_data;
  logic                 data_odd;

  uart_par_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_serial), .dout(rx_s)
  );

  uart_par_rx_bitcnt #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bitcnt (
    .clk(clk), .rst(rst), .restart(cnt_restart), .at_mid(at_mid), .at_end(at_end)
  );

  uart_par_rx_shreg #(.DATA_BITS(DATA_BITS)) u_shreg (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(rx_s),
    .data(shift_data), .ones_odd(data_odd)
  );

  uart_par_rx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .rx_s(rx_s), .at_mid(at_mid), .at_end(at_end),
    .shift_data(shift_data), .data_odd(data_odd),
    .cnt_restart(cnt_restart), .shift_en(shift_en),
    .rx_byte(rx_byte), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/uart_par_rx_chk.sv
module uart_par_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 rx_parity_err,
  input logic                 rx_frame_err,
  input logic                 rx_valid
);
  // R1: the cycle after reset shows cleared outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!rx_valid && rx_byte == '0 && !rx_parity_err && !rx_frame_err));

  // R6: strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6: byte only moves with the strobe
  a_r6_byte_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_byte));

  // R4: parity flag only moves with the strobe
  a_r4_perr_with_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_parity_err) |-> rx_valid);

  // R5: framing flag only moves with the strobe
  a_r5_ferr_with_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_frame_err) |-> rx_valid);
endmodule

bind uart_par_rx uart_par_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_parity_err(rx_parity_err),
  .rx_frame_err(rx_frame_err), .rx_valid(rx_valid)
);

// File: tb/uart_par_rx_tb.sv
module uart_par_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 32;
  localparam int HALF       = (CPB - 1) / 2;
  localparam int LAT        = 10 * CPB + HALF + 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_serial = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_parity_err, rx_frame_err, rx_valid;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int vcnt = 0;
  int last_cyc = 0;
  int t_start = 0;
  logic [7:0] cap [0:3];
  logic       last_perr = 1'b0, last_ferr = 1'b0, prev_valid = 1'b0, dbl = 1'b0;
  logic       timeout = 1'b0;

  uart_par_rx #(.CLKS_PER_BIT(CPB)) u_dut (
    .clk(clk), .rst(rst), .rx_serial(rx_serial), .rx_byte(rx_byte),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .rx_valid(rx_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (prev_valid) dbl = 1'b1;
        cap[vcnt % 4] = rx_byte;
        last_perr = rx_parity_err;
        last_ferr = rx_frame_err;
        last_cyc  = cyc;
        vcnt      = vcnt + 1;
      end
      prev_valid = rx_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v, input int period);
    rx_serial = v;
    repeat (period) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit flip_par, input logic stop_v,
                            input int period);
    @(negedge clk);
    t_start = cyc;
    hold_bit(1'b0, period);
    for (int i = 0; i < 8; i++) hold_bit(b[i], period);
    hold_bit((^b) ^ flip_par, period);
    hold_bit(stop_v, period);
    rx_serial = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
    chk(rx_byte == 8'h00 && !rx_parity_err && !rx_frame_err, "R1 outputs",
        {rx_parity_err, rx_frame_err, rx_byte}, 0);
  endtask

  task automatic t_basic(input logic [7:0] b);
    int n0 = vcnt;
    send_frame(b, 1'b0, 1'b1, CPB);
    repeat (2 * CPB) @(negedge clk);
    chk(vcnt == n0 + 1, "R6 one strobe", vcnt - n0, 1);
    chk(cap[n0 % 4] == b, "R3 byte", cap[n0 % 4], b);
    chk(last_perr == 1'b0, "R4 good parity", last_perr, 0);
    chk(last_ferr == 1'b0, "R5 good stop", last_ferr, 0);
    chk(last_cyc - t_start >= LAT - 1 && last_cyc - t_start <= LAT + 1, "R8 latency",
        last_cyc - t_start, LAT);
    chk(!dbl && rx_valid == 1'b0 && rx_byte == b, "R6 pulse and hold",
        {dbl, rx_valid, rx_byte}, b);
  endtask

  task automatic t_parity(input logic [7:0] b);
    int n0 = vcnt;
    send_frame(b, 1'b1, 1'b1, CPB);
    repeat (2 * CPB) @(negedge clk);
    chk(vcnt == n0 + 1 && cap[n0 % 4] == b, "R4 byte kept", cap[n0 % 4], b);
    chk(last_perr == 1'b1 && last_ferr == 1'b0, "R4 bad parity", {last_perr, last_ferr}, 2);
  endtask

  task automatic t_frame(input logic [7:0] b, input bit flip_par);
    int n0 = vcnt;
    send_frame(b, flip_par, 1'b0, CPB);
    repeat (4 * CPB) @(negedge clk);
    chk(vcnt == n0 + 1, "R5 no extra strobe", vcnt - n0, 1);
    chk(cap[n0 % 4] == b && last_ferr == 1'b1, "R5 stop low", {last_ferr, cap[n0 % 4]},
        {1'b1, b});
    chk(last_perr == flip_par, "R4 with R5 same strobe", last_perr, flip_par);
  endtask

  task automatic t_glitch();
    int n0 = vcnt;
    @(negedge clk);
    hold_bit(1'b0, 3);
    rx_serial = 1'b1;
    repeat (12 * CPB) @(negedge clk);
    chk(vcnt == n0, "R2 false start", vcnt - n0, 0);
    t_basic(8'h5A);
  endtask

  task automatic t_b2b();
    int n0 = vcnt;
    send_frame(8'h11, 1'b0, 1'b1, CPB + 1);
    send_frame(8'h22, 1'b0, 1'b1, CPB + 1);
    send_frame(8'hC3, 1'b0, 1'b1, CPB + 1);
    repeat (2 * CPB) @(negedge clk);
    chk(vcnt == n0 + 3, "R7 frame count", vcnt - n0, 3);
    chk(cap[n0 % 4] == 8'h11, "R7 frame 1", cap[n0 % 4], 8'h11);
    chk(cap[(n0 + 1) % 4] == 8'h22, "R7 frame 2", cap[(n0 + 1) % 4], 8'h22);
    chk(cap[(n0 + 2) % 4] == 8'hC3 && !last_perr && !last_ferr, "R7 frame 3",
        cap[(n0 + 2) % 4], 8'hC3);
  endtask

  task automatic run_all();
    t_reset();
    t_basic(8'hA5);
    t_basic(8'h01);
    t_basic(8'h80);
    t_basic(8'h00);
    t_basic(8'hFF);
    t_parity(8'h3C);
    t_parity(8'h07);
    t_frame(8'h96, 1'b0);
    t_basic(8'h69);
    t_frame(8'h4B, 1'b1);
    t_glitch();
    t_b2b();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule